// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether an incoming Ethernet frame should be kept. It looks at the frame's 48-bit destination address, which the receive path presents one byte per cycle in wire order with a valid strobe. It compares the address with a table of exact entries. Entry 0 is the station's own address, and entries 1 to 3 are meant for multicast groups. For multicast frames it can also consult a 64-bin hash table indexed by bits of the CRC-32 of the address.

Software loads the entries and the hash table through a 16-bit register write port. Two static control inputs select promiscuous operation and enable the hash table. One cycle after the sixth address byte, the block pulses a decision strobe. With the strobe it gives an accept flag and a status word. The status word flags broadcast, multicast, hash hit and exact hit, and it gives the index of the exact entry that matched.

Top module: `rx_addr_filter`

## Requirements
- R1: The write port maps address 3k+w (k = 0..3, w = 0..2) to word w of exact entry k, where word 0 carries the first two wire bytes with the first byte in bits 7:0. Addresses 12..15 load hash words 0..3.
- R2: A destination equal to a non-zero exact entry is accepted and sets status bit 2. Status bits 1:0 hold the entry index, and when several entries match, the lowest index wins.
- R3: An exact entry holding all zeros never matches, not even an all-zero destination.
- R4: The all-ones destination is always accepted and sets status bit 5.
- R5: Status bit 4 (multicast) is set when bit 0 of the first wire byte is 1 and the address is not all ones.
- R6: The hash index is bits 31:26 of a CRC-32 over the six bytes. The CRC uses polynomial 0x04C11DB7, starts at 0xFFFFFFFF, feeds each byte LSB first and applies no final inversion. Index bits 5:4 pick the hash word and bits 3:0 pick the bit within it. A multicast frame whose bit is set is accepted and sets status bit 3.
- R7: The hash table is not consulted (status bit 3 stays 0) when hash enable is low or the frame is not multicast. Loading all four words with 0xFFFF accepts every multicast frame.
- R8: With promiscuous mode on, every frame is accepted, and the status flags are still reported.
- R9: The decision strobe is high for exactly the one cycle after the sixth valid byte. Idle cycles between bytes do not disturb the byte count.
- R10: After reset, the strobe, the accept flag and the status are 0 and all table words are 0.
- R11: When no exact entry matched, status bits 1:0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table word write strobe |
| cfg_addr | input | 4 | Table word address |
| cfg_wdata | input | 16 | Table word data |
| promisc_en | input | 1 | Accept every frame |
| hash_en | input | 1 | Enable the multicast hash table |
| da_valid | input | 1 | Destination byte valid |
| da_byte | input | 8 | Destination byte, wire order |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_status | output | 6 | Match classification flags and exact index |

## Verification
The accept flag, the status word and the strobe all settle at the clock edge that takes in the sixth valid byte. The bench drives each byte on a falling edge and reads the results at the falling edge right after the last byte. One further falling edge later, it confirms that the strobe has dropped. Table writes land on the edge after they are driven, and frames always start after that edge, so every expected value comes from tables that are already loaded. Expected results come from a bench CRC model and a bench table mirror.

// File: rtl/raf_pkg.sv
package raf_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // advance a CRC-32 over one byte, least significant bit first
  function automatic logic [31:0] crc_feed_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/raf_regs.sv
module raf_regs #(
  parameter int N_EXACT    = 4,
  parameter int ENT_WORDS  = 3,
  parameter int WORD_W     = 16,
  parameter int HASH_WORDS = 4,
  parameter int CFG_AW     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 we,
  input  logic [CFG_AW-1:0]                    waddr,
  input  logic [WORD_W-1:0]                    wdata,
  output logic [N_EXACT*ENT_WORDS*WORD_W-1:0]  ent_flat,
  output logic [HASH_WORDS*WORD_W-1:0]         hash_flat
);
  localparam int N_ENT_W = N_EXACT * ENT_WORDS;
  localparam int TOTAL   = N_ENT_W + HASH_WORDS;

  logic [WORD_W-1:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < TOTAL)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < N_ENT_W; g++) begin : g_ent
    assign ent_flat[g*WORD_W +: WORD_W] = mem[g];
  end
  for (genvar h = 0; h < HASH_WORDS; h++) begin : g_hash
    assign hash_flat[h*WORD_W +: WORD_W] = mem[N_ENT_W + h];
  end

  // R1: a write to the first hash word shows up on the table output next cycle
  a_r1_hash_word_load: assert property (@(posedge clk) disable iff (rst)
    (we && int'(waddr) == N_ENT_W) |=> hash_flat[WORD_W-1:0] == $past(wdata));
endmodule

// File: rtl/raf_crc.sv
module raf_crc (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic [7:0]  in_byte,
  output logic [31:0] crc_next
);
  import raf_pkg::*;

  logic [31:0] crc_q;

  assign crc_next = crc_feed_byte(in_first ? CRC_SEED : crc_q, in_byte);

  always_ff @(posedge clk) begin
    if (rst)           crc_q <= CRC_SEED;
    else if (in_valid) crc_q <= crc_next;
  end

  // R6: the accumulator only moves on a valid byte
  a_r6_crc_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(crc_q));
endmodule

// File: rtl/raf_match.sv
module raf_match #(
  parameter int N_EXACT = 4,
  parameter int AW      = 48,
  parameter int IDX_W   = 2
) (
  input  logic [AW-1:0]          addr,
  input  logic [N_EXACT*AW-1:0]  ent_flat,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  logic [N_EXACT-1:0] eq;

  for (genvar k = 0; k < N_EXACT; k++) begin : g_cmp
    logic [AW-1:0] ent;
    assign ent   = ent_flat[k*AW +: AW];
    assign eq[k] = (ent == addr) && (ent != '0);
  end

  always_comb begin
    idx = '0;
    for (int k = N_EXACT - 1; k >= 0; k--) begin
      if (eq[k]) idx = IDX_W'(k);
    end
    hit = |eq;
  end

  // R3: an all-zero destination can only hit an all-zero entry, which is unused
  always_comb begin
    a_r3_zero_entry_quiet: assert (!(hit && addr == '0));
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter  int N_EXACT    = 4,
  parameter  int HASH_WORDS = 4,
  parameter  int WORD_W     = 16,
  parameter  int ADDR_BYTES = 6,
  localparam int AW         = ADDR_BYTES * 8,
  localparam int ENT_WORDS  = AW / WORD_W,
  localparam int CFG_AW     = $clog2(N_EXACT * ENT_WORDS + HASH_WORDS),
  localparam int IDX_W      = $clog2(N_EXACT),
  localparam int ST_W       = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              promisc_en,
  input  logic              hash_en,
  input  logic              da_valid,
  input  logic [7:0]        da_byte,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [ST_W-1:0]   dec_status
);
  localparam int HASH_BITS = $clog2(HASH_WORDS * WORD_W);
  localparam int CNT_W     = $clog2(ADDR_BYTES);
  localparam int S_EXACT   = IDX_W;
  localparam int S_HASH    = IDX_W + 1;
  localparam int S_MCAST   = IDX_W + 2;
  localparam int S_BCAST   = IDX_W + 3;

  logic [N_EXACT*AW-1:0]        ent_flat;
  logic [HASH_WORDS*WORD_W-1:0] hash_flat;
  logic [CNT_W-1:0]             cnt_q;
  logic [AW-9:0]                buf_q;
  logic                         first_b, last_b, fire;
  logic [31:0]                  crc_next;
  logic [AW-1:0]                full_addr;
  logic [HASH_BITS-1:0]         hash_idx;
  logic                         is_bcast, is_mcast, hash_hit, ex_hit, accept_d;
  logic [IDX_W-1:0]             ex_idx;
  logic [ST_W-1:0]              stat_d;

  raf_regs #(
    .N_EXACT(N_EXACT), .ENT_WORDS(ENT_WORDS), .WORD_W(WORD_W),
    .HASH_WORDS(HASH_WORDS), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .ent_flat(ent_flat), .hash_flat(hash_flat)
  );

  assign first_b = (cnt_q == '0);
  assign last_b  = (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign fire    = da_valid && last_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (da_valid) begin
      cnt_q <= last_b ? '0 : cnt_q + 1'b1;
      if (!last_b) buf_q[int'(cnt_q)*8 +: 8] <= da_byte;
    end
  end

  raf_crc u_crc (
    .clk(clk), .rst(rst), .in_valid(da_valid), .in_first(first_b),
    .in_byte(da_byte), .crc_next(crc_next)
  );

  assign full_addr = {da_byte, buf_q};
  assign hash_idx  = crc_next[31 -: HASH_BITS];

  raf_match #(.N_EXACT(N_EXACT), .AW(AW), .IDX_W(IDX_W)) u_match (
    .addr(full_addr), .ent_flat(ent_flat), .hit(ex_hit), .idx(ex_idx)
  );

  always_comb begin
    is_bcast = &full_addr;
    is_mcast = full_addr[0] && !is_bcast;
    hash_hit = hash_en && is_mcast && hash_flat[hash_idx];
    accept_d = promisc_en || is_bcast || ex_hit || hash_hit;
    stat_d            = '0;
    stat_d[IDX_W-1:0] = ex_hit ? ex_idx : '0;
    stat_d[S_EXACT]   = ex_hit;
    stat_d[S_HASH]    = hash_hit;
    stat_d[S_MCAST]   = is_mcast;
    stat_d[S_BCAST]   = is_bcast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_status <= '0;
    end else begin
      dec_valid <= fire;
      if (fire) begin
        dec_accept <= accept_d;
        dec_status <= stat_d;
      end
    end
  end

  // R9: strobe follows the sixth byte by one cycle, and only then
  a_r9_strobe_after_last: assert property (@(posedge clk) disable iff (rst)
    fire |=> dec_valid);
  a_r9_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !dec_valid);
  // R8: promiscuous mode forces acceptance
  a_r8_promisc_accepts: assert property (@(posedge clk) disable iff (rst)
    (fire && promisc_en) |=> dec_accept);
  // R4: a broadcast decision is an acceptance
  a_r4_bcast_accepted: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_status[S_BCAST]) |-> dec_accept);
  // R7: hash hits only come with the multicast flag
  a_r7_hash_needs_mcast: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_status[S_HASH]) |-> dec_status[S_MCAST]);
  // R5: broadcast and multicast flags exclude each other
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !(dec_status[S_BCAST] && dec_status[S_MCAST]));
  // R11: the index is zero without an exact hit
  a_r11_idx_cleared: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_status[S_EXACT]) |-> dec_status[IDX_W-1:0] == '0);
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        promisc_en, hash_en;
  logic        da_valid;
  logic [7:0]  da_byte;
  logic        dec_valid, dec_accept;
  logic [5:0]  dec_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [47:0] m_ent [4];
  logic [63:0] m_hash;
  int unsigned seed;

  always #10 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .promisc_en(promisc_en), .hash_en(hash_en), .da_valid(da_valid), .da_byte(da_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_status(dec_status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      if (c[31] ^ a[i]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_hidx(input logic [47:0] a);
    logic [31:0] c;
    c = ref_crc(a);
    return c[31:26];
  endfunction

  // {accept, status[5:0]}
  function automatic logic [6:0] expect_dec(input logic [47:0] a);
    logic bc, mc, hh, eh;
    logic [1:0] ix;
    logic [5:0] h;
    bc = (a == '1);
    mc = a[0] && !bc;
    h  = ref_hidx(a);
    hh = hash_en && mc && m_hash[{h[5:4], h[3:0]}];
    eh = 1'b0;
    ix = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (m_ent[k] != '0 && m_ent[k] == a) begin
        eh = 1'b1;
        ix = 2'(k);
      end
    end
    return {promisc_en || bc || eh || hh, bc, mc, hh, eh, ix};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_entry(input int k, input logic [47:0] a);
    wr(4'(3*k),     a[15:0]);
    wr(4'(3*k + 1), a[31:16]);
    wr(4'(3*k + 2), a[47:32]);
    m_ent[k] = a;
  endtask

  task automatic set_hash(input logic [63:0] h);
    for (int w = 0; w < 4; w++) wr(4'(12 + w), h[w*16 +: 16]);
    m_hash = h;
  endtask

  task automatic send_chk(input logic [47:0] a, input int gap, input string req);
    logic [6:0] e;
    e = expect_dec(a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_byte = a[i*8 +: 8];
      if (gap > 0 && i < 5) begin
        @(negedge clk);
        da_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    da_valid = 1'b0;
    check(dec_valid == 1'b1, req, "strobe", 32'(dec_valid), 32'd1);
    check({dec_accept, dec_status} == e, req, "decision", 32'({dec_accept, dec_status}), 32'(e));
    @(negedge clk);
    check(dec_valid == 1'b0, "R9", "strobe drop", 32'(dec_valid), 32'd0);
  endtask

  initial begin
    logic [47:0] a, hm;
    logic [5:0]  hi;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    promisc_en = 0; hash_en = 0; da_valid = 0; da_byte = 0;
    for (int k = 0; k < 4; k++) m_ent[k] = '0;
    m_hash = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(dec_valid == 0,  "R10", "strobe", 32'(dec_valid), 0);
    check(dec_accept == 0, "R10", "accept", 32'(dec_accept), 0);
    check(dec_status == 0, "R10", "status", 32'(dec_status), 0);
    // R10/R3: empty tables reject an all-zero unicast address
    send_chk(48'h0, 0, "R3");

    // R1/R2: station entry, multicast entries
    set_entry(0, 48'h5544_3322_1100);
    set_entry(1, 48'h0000_5E00_0001);
    set_entry(2, 48'hFF00_0000_0033);
    send_chk(48'h5544_3322_1100, 0, "R2");
    send_chk(48'h0000_5E00_0001, 0, "R2");
    send_chk(48'hFF00_0000_0033, 0, "R1");
    // R2: lowest index wins when two entries agree
    set_entry(3, 48'h0000_5E00_0001);
    send_chk(48'h0000_5E00_0001, 0, "R2");
    // R3: zero entry stays unused for a zero address
    set_entry(3, 48'h0);
    send_chk(48'h0, 0, "R3");
    // R4: broadcast
    send_chk(48'hFFFF_FFFF_FFFF, 0, "R4");
    // R5: unmatched multicast, hash off
    send_chk(48'h1234_5678_9A01, 0, "R5");
    // R9: idle cycles between bytes
    send_chk(48'h5544_3322_1100, 2, "R9");

    // R6: exactly one hash bit set
    hm = 48'hABCD_EF01_2345;
    hi = ref_hidx(hm);
    set_hash(64'd1 << hi);
    hash_en = 1'b1;
    send_chk(hm, 0, "R6");
    set_hash(~(64'd1 << hi));
    send_chk(hm, 0, "R6");
    // R7: all-ones table accepts multicast, ignores unicast, off when disabled
    set_hash('1);
    send_chk(48'h7766_5544_3303, 0, "R7");
    send_chk(48'h7766_5544_3302, 0, "R7");
    hash_en = 1'b0;
    send_chk(48'h7766_5544_3303, 0, "R7");
    // R8: promiscuous
    promisc_en = 1'b1;
    send_chk(48'h0102_0304_0506, 0, "R8");
    promisc_en = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      if (n % 25 == 0) begin
        for (int k = 0; k < 4; k++) begin
          a = {$urandom, $urandom};
          if ($urandom % 4 == 0) a = '0;
          else if (k > 0) a[0] = 1'b1;
          set_entry(k, a);
        end
        set_hash({$urandom, $urandom});
        hash_en    = ($urandom % 3) != 0;
        promisc_en = ($urandom % 6) == 0;
      end
      sel = int'($urandom % 10);
      a = {$urandom, $urandom};
      if (sel < 3)       a = m_ent[$urandom % 4];
      else if (sel == 3) a = '1;
      else if (sel < 7)  a[0] = 1'b1;
      else               a[0] = 1'b0;
      send_chk(a, int'($urandom % 2), "R6");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule